// File: doc/BRIEF.md
# Watchdog Timer with Control/Status Register

This block supervises software progress. It holds a single 8-bit control/status register on a simple processor register bus. Software enables the supervisor, picks one of eight timeout lengths and proves it is alive by setting two refresh bits in a fixed order. A 16-bit counter advances on a millisecond tick supplied from outside the block. If the counter reaches the selected limit before a valid refresh arrives, the block raises a system reset request for one clock.

The request also returns the register to a quiet state and sets a status flag. That flag survives the reset the block itself causes. Software can read it after restart to learn why the chip restarted. Only a software write of zero or the external hardware reset clears the flag. The register accepts both whole-byte writes and single-bit writes.

Top module: `wdg_timer`

## Requirements
- R1: While `extRstN` is low, every register bit clears, so the register reads 0x00 and `wdResetReq` stays low.
- R2: The register answers only at bus address `REG_ADDR` (default 0xC0). Writes to any other address change nothing. Reads at any other address return 0x00. The register reads {prescale[2:0] at bits 7:5, 0 at bit 4, first-refresh bit at bit 3, 0 at bit 2, status at bit 1, enable at bit 0}.
- R3: With `busBitEn` high, a write changes only the bit at position `busBitSel` to `busBitVal`. All other bits keep their current value.
- R4: Once the counter is cleared with the enable bit at 1, the reset request appears after exactly 16 × 2^prescale ticks, visible one clock after the final tick.
- R5: `wdResetReq` is high for exactly one clock per timeout.
- R6: A timeout sets the status bit and clears prescale, the first-refresh bit and enable. The register then reads 0x02.
- R7: Writing 0 to the status bit clears it. Writing 1 to it never sets it. A write that leaves the bit at 1 keeps it set.
- R8: A refresh is valid when bit 2 is written as 1 while bit 3 was already set by an earlier write. A valid refresh clears the counter and bit 3, so the next timeout comes a full period later.
- R9: Writing bit 2 as 1 while bit 3 is clear does not refresh, including when the same write also sets bit 3. Bit 2 reads back as 0, and any bit 3 value from that write is kept.
- R10: While enable is 0 the counter stays cleared and no request is raised. A 0-to-1 write of enable restarts the full period.
- R11: A valid refresh, or a write that clears enable, in the same clock as the final tick prevents the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| extRstN | input | 1 | External hardware reset, active low, clears every bit |
| tick | input | 1 | One-clock strobe, once per millisecond |
| busAddr | input | 8 | Register bus address |
| busWrEn | input | 1 | Write strobe |
| busBitEn | input | 1 | 1: single-bit write, 0: byte write |
| busBitSel | input | 3 | Bit position for a single-bit write |
| busBitVal | input | 1 | Value for a single-bit write |
| busWrData | input | 8 | Byte write data |
| busRdData | output | 8 | Read data, combinational from `busAddr` |
| wdResetReq | output | 1 | One-clock system reset request |

## Verification
The assertions check on every cycle that the request is a single clock wide and that it coincides with the post-timeout register state. They also check that the status flag holds unless a write clears it, that a disabled supervisor raises no request and keeps its counter at zero, and that a valid refresh blocks a request in the next cycle. Exact timeout lengths for several prescale values, refresh ordering across separate writes, and same-cycle races between the last tick and a write can only be shown by the bench's scenarios. The bench's per-cycle reference model also shows the single-bit write merging and the recovery from an external reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // register bit positions (software-visible layout)
  localparam int unsigned BitEn   = 0;
  localparam int unsigned BitSts  = 1;
  localparam int unsigned BitOrd2 = 2;
  localparam int unsigned BitOrd1 = 3;
  localparam int unsigned PreLsb  = 5;
  localparam int unsigned PreW    = 3;

  // control -> datapath strobes
  typedef struct packed {
    logic clr;
    logic run;
  } cntCmd_t;
endpackage

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned BASE_TICKS = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wdg_pkg::cntCmd_t        cmd,
  input  logic                    tick,
  input  logic [wdg_pkg::PreW-1:0] pre,
  output logic                    expire
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limitM1;

  assign limitM1 = (CNT_W'(BASE_TICKS) << pre) - CNT_W'(1);
  // >= so a shorter prescale written mid-period still expires
  assign expire  = cmd.run & tick & (count >= limitM1);

  always_ff @(posedge clk) begin
    if (!rstN)                 count <= '0;
    else if (cmd.clr)          count <= '0;
    else if (cmd.run && tick)  count <= count + CNT_W'(1);
  end

  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.run |=> (count == '0)); // R10
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs #(
  parameter int unsigned        ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]  REG_ADDR = 8'hC0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic                     busBitEn,
  input  logic [2:0]               busBitSel,
  input  logic                     busBitVal,
  input  logic [7:0]               busWrData,
  input  logic                     expire,
  output wdg_pkg::cntCmd_t         cmd,
  output logic [wdg_pkg::PreW-1:0] pre,
  output logic [7:0]               rdData,
  output logic                     resetReq
);
  import wdg_pkg::*;

  logic [PreW-1:0] preQ;
  logic ord1Q, stsQ, enQ, reqQ;
  logic [7:0] view, merged;
  logic hit, newEn, refresh, enRise, fire;

  always_comb begin
    view = 8'h00;
    view[PreLsb +: PreW] = preQ;
    view[BitOrd1] = ord1Q;
    view[BitSts]  = stsQ;
    view[BitEn]   = enQ;
  end

  always_comb begin
    merged = view;
    if (busBitEn) merged[busBitSel] = busBitVal;
    else          merged = busWrData;
  end

  assign hit     = busWrEn && (busAddr == REG_ADDR);
  assign newEn   = hit ? merged[BitEn] : enQ;
  assign refresh = hit && merged[BitOrd2] && ord1Q;
  assign enRise  = hit && merged[BitEn] && !enQ;
  assign fire    = expire && !refresh && newEn;

  assign cmd.run = enQ;
  assign cmd.clr = refresh | enRise | fire | ~enQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ  <= '0;
      ord1Q <= 1'b0;
      stsQ  <= 1'b0;
      enQ   <= 1'b0;
      reqQ  <= 1'b0;
    end else begin
      reqQ <= fire;
      if (fire) begin
        preQ  <= '0;
        ord1Q <= 1'b0;
        enQ   <= 1'b0;
        stsQ  <= 1'b1;
      end else if (hit) begin
        preQ  <= merged[PreLsb +: PreW];
        enQ   <= merged[BitEn];
        stsQ  <= stsQ & merged[BitSts];
        ord1Q <= refresh ? 1'b0 : merged[BitOrd1];
      end
    end
  end

  assign pre      = preQ;
  assign resetReq = reqQ;
  assign rdData   = (busAddr == REG_ADDR) ? view : 8'h00;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqQ |=> !reqQ); // R5
  AST_REQ_STATE: assert property (@(posedge clk) disable iff (!rstN)
    reqQ |-> (stsQ && !enQ && !ord1Q && preQ == '0)); // R6
  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (stsQ && !(hit && !merged[BitSts])) |=> stsQ); // R7
  AST_REFRESH_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (hit && merged[BitOrd2] && ord1Q) |=> !reqQ); // R11
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> !reqQ); // R10
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer #(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR   = 8'hC0,
  parameter int unsigned       CNT_W      = 16,
  parameter int unsigned       BASE_TICKS = 16
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busBitEn,
  input  logic [2:0]        busBitSel,
  input  logic              busBitVal,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              wdResetReq
);
  wdg_pkg::cntCmd_t          cmd;
  logic [wdg_pkg::PreW-1:0]  pre;
  logic                      expire;

  wdg_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) uRegs (
    .clk(clk), .rstN(extRstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busBitEn(busBitEn), .busBitSel(busBitSel), .busBitVal(busBitVal),
    .busWrData(busWrData), .expire(expire), .cmd(cmd), .pre(pre),
    .rdData(busRdData), .resetReq(wdResetReq)
  );

  wdg_count #(.CNT_W(CNT_W), .BASE_TICKS(BASE_TICKS)) uCount (
    .clk(clk), .rstN(extRstN), .cmd(cmd), .tick(tick), .pre(pre),
    .expire(expire)
  );
endmodule

// File: tb/tb_wdg_timer.sv
module tb_wdg_timer;
  logic clk = 1'b0;
  logic extRstN = 1'b0;
  logic tick = 1'b0;
  logic [7:0] busAddr = 8'hC0;
  logic busWrEn = 1'b0, busBitEn = 1'b0, busBitVal = 1'b0;
  logic [2:0] busBitSel = 3'd0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic wdResetReq;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  int mPre = 0, mOrd1 = 0, mSts = 0, mEn = 0, mCnt = 0, mReq = 0;

  always #4 clk = ~clk;

  wdg_timer dut (
    .clk(clk), .extRstN(extRstN), .tick(tick), .busAddr(busAddr),
    .busWrEn(busWrEn), .busBitEn(busBitEn), .busBitSel(busBitSel),
    .busBitVal(busBitVal), .busWrData(busWrData), .busRdData(busRdData),
    .wdResetReq(wdResetReq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mView();
    return (mPre << 5) | (mOrd1 << 3) | (mSts << 1) | mEn;
  endfunction

  // behavioural reference, one step per clock
  always @(posedge clk) begin
    if (!extRstN) begin
      mPre = 0; mOrd1 = 0; mSts = 0; mEn = 0; mCnt = 0; mReq = 0;
    end else begin
      int nv, limit;
      bit wr, refr, rise, newEn, exp_, fire;
      nv = mView();
      wr = busWrEn && busAddr == 8'hC0;
      if (wr) begin
        if (busBitEn) begin
          if (busBitVal) nv = nv | (1 << busBitSel);
          else           nv = nv & ~(1 << busBitSel);
        end else nv = busWrData;
      end
      limit = 16 * (2 ** mPre);
      newEn = wr ? nv[0] : mEn[0];
      refr  = wr && nv[2] && mOrd1 != 0;
      rise  = wr && nv[0] && mEn == 0;
      exp_  = mEn != 0 && tick && mCnt >= limit - 1;
      fire  = exp_ && !refr && newEn;
      mReq  = fire;
      if (refr || rise || fire || mEn == 0) mCnt = 0;
      else if (tick) mCnt = mCnt + 1;
      if (fire) begin
        mPre = 0; mOrd1 = 0; mEn = 0; mSts = 1;
      end else if (wr) begin
        mPre = (nv >> 5) & 7;
        mEn  = nv & 1;
        mSts = mSts & ((nv >> 1) & 1);
        mOrd1 = refr ? 0 : ((nv >> 3) & 1);
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (!finished) begin
      chk("R4 R6 model wdResetReq", wdResetReq, mReq);
      chk("R2 R3 model busRdData", busRdData, (busAddr == 8'hC0) ? mView() : 0);
    end
  end

  task automatic wr_byte(input logic [7:0] d, input logic [7:0] a = 8'hC0);
    @(negedge clk);
    busAddr = a; busWrEn = 1; busBitEn = 0; busWrData = d;
    @(negedge clk);
    busWrEn = 0; busAddr = 8'hC0;
  endtask

  task automatic wr_bit(input int sel, input bit val);
    @(negedge clk);
    busWrEn = 1; busBitEn = 1; busBitSel = 3'(sel); busBitVal = val;
    @(negedge clk);
    busWrEn = 0; busBitEn = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input int exp);
    @(negedge clk);
    busAddr = a;
    #1;
    chk(tag, busRdData, exp);
    busAddr = 8'hC0;
  endtask

  // returns tick index of first request and number of high request cycles
  task automatic run_ticks(input int n, output int first, output int hiCyc);
    first = 0; hiCyc = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); tick = 1;
      @(posedge clk); #2;
      if (wdResetReq) begin hiCyc++; if (first == 0) first = i; end
      @(negedge clk); tick = 0;
      @(posedge clk); #2;
      if (wdResetReq) hiCyc++;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired R4 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first, hi;
    repeat (3) @(negedge clk);
    #1; chk("R1 read in reset", busRdData, 0);
    chk("R1 req in reset", wdResetReq, 0);
    extRstN = 1;
    rd_chk("R1 read after reset", 8'hC0, 8'h00);

    // R2 address decode
    wr_byte(8'hFF, 8'h40);
    rd_chk("R2 other address ignored", 8'hC0, 8'h00);
    rd_chk("R2 other address reads zero", 8'h40, 8'h00);
    // byte 0xFF: bit2 ignored (R9), status not set (R7), bit4 zero (R2)
    wr_byte(8'hFF);
    rd_chk("R9 R7 byte FF readback", 8'hC0, 8'hE9);
    wr_byte(8'h00);

    // R3 single-bit writes
    wr_bit(5, 1); rd_chk("R3 bit5 set", 8'hC0, 8'h20);
    wr_bit(7, 1); rd_chk("R3 bit7 set", 8'hC0, 8'hA0);
    wr_bit(5, 0); rd_chk("R3 bit5 clear", 8'hC0, 8'h80);
    wr_byte(8'h00);

    // R4 R5 R6 shortest period
    wr_byte(8'h01);
    run_ticks(20, first, hi);
    chk("R4 prescale0 ticks", first, 16);
    chk("R5 pulse width", hi, 1);
    rd_chk("R6 state after timeout", 8'hC0, 8'h02);

    // R7 status behaviour
    wr_byte(8'h03); rd_chk("R7 write 1 keeps status", 8'hC0, 8'h03);
    wr_byte(8'h01); rd_chk("R7 write 0 clears status", 8'hC0, 8'h01);
    wr_bit(1, 1);   rd_chk("R7 write 1 cannot set", 8'hC0, 8'h01);
    wr_byte(8'h00);

    // R4 other prescales
    wr_byte(8'h41);
    run_ticks(70, first, hi);
    chk("R4 prescale2 ticks", first, 64);
    wr_byte(8'h00);
    wr_byte(8'hE1);
    run_ticks(2060, first, hi);
    chk("R4 prescale7 ticks", first, 2048);
    chk("R5 pulse width long", hi, 1);
    wr_byte(8'h00);

    // R8 valid refresh
    wr_byte(8'h21);
    run_ticks(20, first, hi);
    chk("R8 no early timeout", first, 0);
    wr_bit(3, 1); rd_chk("R8 first refresh bit set", 8'hC0, 8'h29);
    wr_bit(2, 1); rd_chk("R8 refresh clears bit3", 8'hC0, 8'h21);
    run_ticks(40, first, hi);
    chk("R8 full period after refresh", first, 32);
    wr_byte(8'h00);

    // R9 wrong order
    wr_byte(8'h21);
    run_ticks(20, first, hi);
    wr_bit(2, 1); rd_chk("R9 bit2 ignored", 8'hC0, 8'h21);
    wr_bit(3, 1); rd_chk("R9 bit3 kept", 8'hC0, 8'h29);
    run_ticks(20, first, hi);
    chk("R9 no refresh happened", first, 12);
    rd_chk("R6 bit3 cleared by timeout", 8'hC0, 8'h02);
    wr_byte(8'h00);

    // R10 disable and re-enable
    wr_byte(8'h01);
    run_ticks(10, first, hi);
    wr_byte(8'h00);
    run_ticks(40, first, hi);
    chk("R10 disabled no request", first, 0);
    wr_byte(8'h01);
    run_ticks(10, first, hi);
    wr_byte(8'h00);
    wr_byte(8'h01);
    run_ticks(20, first, hi);
    chk("R10 re-enable restarts period", first, 16);
    wr_byte(8'h00);

    // R11 refresh on the final tick
    wr_byte(8'h01);
    run_ticks(15, first, hi);
    wr_bit(3, 1);
    @(negedge clk);
    tick = 1; busWrEn = 1; busBitEn = 1; busBitSel = 3'd2; busBitVal = 1;
    @(posedge clk); #2;
    chk("R11 refresh beats final tick", wdResetReq, 0);
    @(negedge clk);
    tick = 0; busWrEn = 0; busBitEn = 0;
    run_ticks(20, first, hi);
    chk("R11 period after race refresh", first, 16);
    wr_byte(8'h00);

    // R11 disable on the final tick
    wr_byte(8'h01);
    run_ticks(15, first, hi);
    @(negedge clk);
    tick = 1; busWrEn = 1; busWrData = 8'h00;
    @(posedge clk); #2;
    chk("R11 disable beats final tick", wdResetReq, 0);
    @(negedge clk);
    tick = 0; busWrEn = 0;
    run_ticks(20, first, hi);
    chk("R11 stays quiet after disable", first, 0);

    // R1 external reset clears sticky status
    wr_byte(8'h01);
    run_ticks(16, first, hi);
    rd_chk("R6 status before hw reset", 8'hC0, 8'h02);
    @(negedge clk); extRstN = 0;
    repeat (2) @(negedge clk);
    extRstN = 1;
    rd_chk("R1 hw reset clears status", 8'hC0, 8'h00);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule